// File: doc/BRIEF.md
# Page-Write EEPROM Command Interface

This block is the device side of a byte-wide nonvolatile memory that is written a page at a time. A host drives a parallel bus: an active-low chip enable, an active-low output enable, an active-low write enable, a 16-bit address and an 8-bit data bus. All bus inputs are sampled on the block clock. The read data comes out on a separate output.

Writes to the array are locked. A page is programmed only after a three-write unlock. The host then sends up to a full page of bytes, which collect in a page buffer. When the bus stays quiet for a programmable number of cycles, the block starts an internally timed cycle. That cycle erases the page and programs it in a single step. While the cycle runs, every read returns status instead of array data: a bit that carries the complement of the last loaded data, and a bit that flips on every read.

Further command sequences do three other jobs. One enters an identification mode and another leaves it. A six-write sequence erases the whole array. The array is a plain behavioural RAM. Its page count is a parameter, and every internal duration is a parameter given as a clock-cycle count.

Top module: `pgw_eeprom`

## Requirements
- R1: The array holds 2^PAGE_BITS pages of 2^BYTE_BITS bytes (defaults 8 × 128). The byte index is addr[BYTE_BITS-1:0] and the page index is the PAGE_BITS bits above it. Higher address bits are ignored for array access, so addresses alias. After reset every byte reads FFH.
- R2: A read access starts in the first cycle in which ceN=0, oeN=0 and weN=1 hold after a cycle in which they did not all hold. The value read appears on dataOut one clock after that cycle. At all other times dataOut holds its value, and it is 00H during reset.
- R3: A bus write is taken once, in the first cycle of each period in which ceN=0 and weN=0. Holding that condition for several cycles still counts as a single write.
- R4: A page write is unlocked by three writes in this order: AAH to 5555H, 55H to 2AAAH, A0H to 5555H. Unlock addresses are compared on addr[14:0] only.
- R5: After the unlock, each write stores its data into the page buffer at its byte index. The page is taken from the first loaded byte. The internal cycle rewrites the whole page, so a byte that was not loaded reads FFH afterwards.
- R6: The internal cycle starts LOAD_TIMEOUT clocks after the last loaded byte if no further write arrives. If no byte at all was loaded within LOAD_TIMEOUT clocks of the unlock, the block returns to idle and nothing changes.
- R7: While an internal cycle is busy, every read at any address returns bit 7 as the complement of bit 7 of the last loaded byte, with bits 5:0 equal to zero.
- R8: While busy, bit 6 of the status read is 1 on the first read after the cycle starts and inverts on each further read.
- R9: The page cycle lasts WRITE_CYCLES clocks. The first read that starts after it ends returns the new array data.
- R10: A write that arrives while a cycle is busy is ignored. A write that is not preceded by a valid unlock never changes the array.
- R11: Any write that does not match the next expected step of a command sequence returns the decoder to idle, and the following write is decoded as the start of a new sequence.
- R12: The three-write prefix followed by 90H@5555H enters identification mode. In that mode a read of address 0000H returns BFH, a read of 0001H returns 5DH, and a read of any other address returns 00H. The prefix followed by F0H@5555H restores array reads.
- R13: The six writes AAH@5555H, 55H@2AAAH, 80H@5555H, AAH@5555H, 55H@2AAAH, 10H@5555H start a chip erase. The erase is busy for ERASE_CYCLES clocks, and its status bit 7 reads 0. Afterwards every byte reads FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | 16 | Bus address |
| dataIn | input | 8 | Write data from the host |
| dataOut | output | 8 | Read data or busy status |

## Verification
The hardest states to reach from the pins are the edges of the busy window. One is the single clock at which the load timeout fires. Another is the last busy clock, where a read still returns status while the next read returns the array. Writes that arrive inside the window must leave no trace. The stimulus reaches these edges by issuing reads back to back across the whole end of a page cycle. It also fires a complete unlock and a data byte into the middle of a busy cycle, and then reads the target byte after the decoder has had time to time out. A cycle-accurate behavioural model in the bench predicts dataOut on every clock, so a status value that appears one cycle early or late is caught wherever it happens.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_C1,
    ST_C2,
    ST_E3,
    ST_E4,
    ST_E5,
    ST_LOAD,
    ST_PROG,
    ST_ERASE
  } seqState_t;

  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;

  localparam logic [7:0] CMD_AA     = 8'hAA;
  localparam logic [7:0] CMD_55     = 8'h55;
  localparam logic [7:0] CMD_LOAD   = 8'hA0;
  localparam logic [7:0] CMD_ID_IN  = 8'h90;
  localparam logic [7:0] CMD_ID_OUT = 8'hF0;
  localparam logic [7:0] CMD_ERASE1 = 8'h80;
  localparam logic [7:0] CMD_ERASE2 = 8'h10;

  localparam logic [7:0] ID_MAKER = 8'hBF;
  localparam logic [7:0] ID_PART  = 8'h5D;

  typedef struct packed {
    logic rdStb;       // start of a read access
    logic busy;        // internal cycle running
    logic idMode;      // identification reads
    logic bufClear;    // preset page buffer to FF
    logic loadByte;    // store dataIn into page buffer
    logic progEn;      // copy one buffer byte into the array
    logic eraseEn;     // wipe one array byte
    logic busyStart;   // internal cycle begins next clock
    logic eraseStart;  // chip erase begins next clock
  } ctrlStrobe_t;

endpackage

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int BYTE_BITS    = 7,
  parameter int PAGE_BITS    = 3,
  parameter int LOAD_TIMEOUT = 40,
  parameter int WRITE_CYCLES = 200,
  parameter int ERASE_CYCLES = 1100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ceN,
  input  logic                 oeN,
  input  logic                 weN,
  input  logic [14:0]          cmdAddr,
  input  logic [7:0]           dataIn,
  output ctrlStrobe_t          strb,
  output logic [PAGE_BITS-1:0] pageSel,
  output logic [BYTE_BITS-1:0] progIdx,
  output logic [BYTE_BITS+PAGE_BITS-1:0] wipeIdx
);

  localparam int AW      = BYTE_BITS + PAGE_BITS;
  localparam int DEPTH   = 1 << AW;
  localparam int PBYTES  = 1 << BYTE_BITS;
  localparam int TW      = $clog2(LOAD_TIMEOUT + 1);
  localparam int MAXBUSY = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
  localparam int CW      = $clog2(MAXBUSY + 1);

  localparam logic [TW-1:0] LD_LAST = TW'(LOAD_TIMEOUT - 1);
  localparam logic [CW-1:0] WR_LAST = CW'(WRITE_CYCLES - 1);
  localparam logic [CW-1:0] ER_LAST = CW'(ERASE_CYCLES - 1);
  localparam logic [CW-1:0] PB_CNT  = CW'(PBYTES);
  localparam logic [CW-1:0] DP_CNT  = CW'(DEPTH);

  logic wrAct, rdAct, wrActQ, rdActQ, wrStb, rdStb;
  logic hitA, hitB;
  seqState_t st;
  logic idQ;
  logic anyLd;
  logic [TW-1:0] ldTmr;
  logic [CW-1:0] busyCnt;
  logic [PAGE_BITS-1:0] pageQ;
  logic timeoutHit;

  assign wrAct = !ceN && !weN;
  assign rdAct = !ceN && !oeN && weN;
  assign wrStb = wrAct && !wrActQ;
  assign rdStb = rdAct && !rdActQ;
  assign hitA  = (cmdAddr == UNLOCK_A);
  assign hitB  = (cmdAddr == UNLOCK_B);
  assign timeoutHit = (st == ST_LOAD) && !wrStb && (ldTmr == LD_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrActQ  <= 1'b0;
      rdActQ  <= 1'b0;
      st      <= ST_IDLE;
      idQ     <= 1'b0;
      anyLd   <= 1'b0;
      ldTmr   <= '0;
      busyCnt <= '0;
      pageQ   <= '0;
    end else begin
      wrActQ <= wrAct;
      rdActQ <= rdAct;
      case (st)
        ST_IDLE: begin
          if (wrStb && hitA && dataIn == CMD_AA) st <= ST_C1;
        end
        ST_C1: begin
          if (wrStb) st <= (hitB && dataIn == CMD_55) ? ST_C2 : ST_IDLE;
        end
        ST_C2: begin
          if (wrStb) begin
            st <= ST_IDLE;
            if (hitA) begin
              case (dataIn)
                CMD_LOAD: begin
                  st    <= ST_LOAD;
                  ldTmr <= '0;
                  anyLd <= 1'b0;
                end
                CMD_ID_IN:  idQ <= 1'b1;
                CMD_ID_OUT: idQ <= 1'b0;
                CMD_ERASE1: st  <= ST_E3;
                default: ;
              endcase
            end
          end
        end
        ST_E3: begin
          if (wrStb) st <= (hitA && dataIn == CMD_AA) ? ST_E4 : ST_IDLE;
        end
        ST_E4: begin
          if (wrStb) st <= (hitB && dataIn == CMD_55) ? ST_E5 : ST_IDLE;
        end
        ST_E5: begin
          if (wrStb) begin
            if (hitA && dataIn == CMD_ERASE2) begin
              st      <= ST_ERASE;
              busyCnt <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_LOAD: begin
          if (wrStb) begin
            ldTmr <= '0;
            anyLd <= 1'b1;
            if (!anyLd) pageQ <= cmdAddr[BYTE_BITS +: PAGE_BITS];
          end else if (ldTmr == LD_LAST) begin
            st      <= anyLd ? ST_PROG : ST_IDLE;
            busyCnt <= '0;
          end else begin
            ldTmr <= ldTmr + TW'(1);
          end
        end
        ST_PROG: begin
          if (busyCnt == WR_LAST) st <= ST_IDLE;
          else busyCnt <= busyCnt + CW'(1);
        end
        ST_ERASE: begin
          if (busyCnt == ER_LAST) st <= ST_IDLE;
          else busyCnt <= busyCnt + CW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb            = '0;
    strb.rdStb      = rdStb;
    strb.busy       = (st == ST_PROG) || (st == ST_ERASE);
    strb.idMode     = idQ;
    strb.bufClear   = (st == ST_C2) && wrStb && hitA && (dataIn == CMD_LOAD);
    strb.loadByte   = (st == ST_LOAD) && wrStb;
    strb.progEn     = (st == ST_PROG) && (busyCnt < PB_CNT);
    strb.eraseEn    = (st == ST_ERASE) && (busyCnt < DP_CNT);
    strb.eraseStart = (st == ST_E5) && wrStb && hitA && (dataIn == CMD_ERASE2);
    strb.busyStart  = (timeoutHit && anyLd) || strb.eraseStart;
  end

  assign pageSel = pageQ;
  assign progIdx = busyCnt[BYTE_BITS-1:0];
  assign wipeIdx = busyCnt[AW-1:0];

  // R10: a write inside a busy page cycle does not end the cycle early
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PROG && wrStb && busyCnt != WR_LAST) |=> (st == ST_PROG));

  // R6: the page cycle is entered only from byte loading
  a_r6_prog_from_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st == ST_PROG) |-> $past(st == ST_LOAD));

  // R5: loading, programming and erasing never overlap
  a_r5_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadByte, strb.progEn, strb.eraseEn}));

  // R11: a mismatching second write drops the decoder to idle
  a_r11_seq_break: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_C1 && wrStb && !(hitB && dataIn == CMD_55)) |=> (st == ST_IDLE));

  // R3: a write held low for several cycles yields one strobe
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb);

endmodule

// File: rtl/pgw_dpath.sv
module pgw_dpath
  import pgw_pkg::*;
#(
  parameter int BYTE_BITS = 7,
  parameter int PAGE_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strb,
  input  logic [15:0]          addr,
  input  logic [7:0]           dataIn,
  input  logic [PAGE_BITS-1:0] pageSel,
  input  logic [BYTE_BITS-1:0] progIdx,
  input  logic [BYTE_BITS+PAGE_BITS-1:0] wipeIdx,
  output logic [7:0]           dataOut
);

  localparam int AW     = BYTE_BITS + PAGE_BITS;
  localparam int DEPTH  = 1 << AW;
  localparam int PBYTES = 1 << BYTE_BITS;

  logic [7:0] arr [DEPTH];
  logic [7:0] pageBuf [PBYTES];
  logic [7:0] lastData;
  logic       togQ;
  logic [7:0] rdVal;
  logic [7:0] idVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= 8'hFF;
    end else begin
      if (strb.progEn) arr[{pageSel, progIdx}] <= pageBuf[progIdx];
      if (strb.eraseEn) arr[wipeIdx] <= 8'hFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.bufClear) begin
      for (int i = 0; i < PBYTES; i++) pageBuf[i] <= 8'hFF;
    end else if (strb.loadByte) begin
      pageBuf[addr[BYTE_BITS-1:0]] <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastData <= 8'h00;
      togQ     <= 1'b0;
      dataOut  <= 8'h00;
    end else begin
      if (strb.loadByte) lastData <= dataIn;
      else if (strb.eraseStart) lastData <= 8'hFF;
      if (strb.busyStart) togQ <= 1'b0;
      else if (strb.rdStb && strb.busy) togQ <= ~togQ;
      if (strb.rdStb) dataOut <= rdVal;
    end
  end

  always_comb begin
    if (addr == 16'h0000)      idVal = ID_MAKER;
    else if (addr == 16'h0001) idVal = ID_PART;
    else                       idVal = 8'h00;
    if (strb.busy)        rdVal = {~lastData[7], ~togQ, 6'b0};
    else if (strb.idMode) rdVal = idVal;
    else                  rdVal = arr[addr[AW-1:0]];
  end

  // R7: a busy read shows the complemented data bit and zero low bits
  a_r7_poll_bit: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStb && strb.busy) |=> (dataOut[7] == ~lastData[7] && dataOut[5:0] == 6'b0));

  // R8: each busy read inverts the toggle bit
  a_r8_toggle_flip: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStb && strb.busy) |=> (dataOut[6] != $past(togQ)));

  // R2: without a read start the output holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdStb |=> $stable(dataOut));

endmodule

// File: rtl/pgw_eeprom.sv
module pgw_eeprom
  import pgw_pkg::*;
#(
  parameter int BYTE_BITS    = 7,
  parameter int PAGE_BITS    = 3,
  parameter int LOAD_TIMEOUT = 40,
  parameter int WRITE_CYCLES = 200,
  parameter int ERASE_CYCLES = 1100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  input  logic [15:0] addr,
  input  logic [7:0]  dataIn,
  output logic [7:0]  dataOut
);

  localparam int AW = BYTE_BITS + PAGE_BITS;

  ctrlStrobe_t          strb;
  logic [PAGE_BITS-1:0] pageSel;
  logic [BYTE_BITS-1:0] progIdx;
  logic [AW-1:0]        wipeIdx;

  pgw_ctrl #(
    .BYTE_BITS(BYTE_BITS), .PAGE_BITS(PAGE_BITS), .LOAD_TIMEOUT(LOAD_TIMEOUT),
    .WRITE_CYCLES(WRITE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .cmdAddr(addr[14:0]), .dataIn(dataIn), .strb(strb),
    .pageSel(pageSel), .progIdx(progIdx), .wipeIdx(wipeIdx)
  );

  pgw_dpath #(.BYTE_BITS(BYTE_BITS), .PAGE_BITS(PAGE_BITS)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .dataIn(dataIn),
    .pageSel(pageSel), .progIdx(progIdx), .wipeIdx(wipeIdx), .dataOut(dataOut)
  );

endmodule

// File: tb/tb_pgw_eeprom.sv
module tb_pgw_eeprom;

  localparam int LT  = 40;
  localparam int WR  = 200;
  localparam int ER  = 1100;
  localparam int DEP = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [15:0] addr = 16'h0;
  logic [7:0] dataIn = 8'h0;
  wire  [7:0] dataOut;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;
  string curReq = "R2";

  always #2 clk = ~clk;

  pgw_eeprom #(.BYTE_BITS(7), .PAGE_BITS(3), .LOAD_TIMEOUT(LT),
               .WRITE_CYCLES(WR), .ERASE_CYCLES(ER)) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut));

  // behavioural reference model
  logic [7:0] mMem [DEP];
  logic [7:0] mBuf [128];
  logic [7:0] expOut, lastD;
  int mst, busyLeft, ldT, ldPage;
  bit mId, busyErase, ldAny, tog, mWrQ, mRdQ;

  always @(posedge clk) begin
    bit wa, ra, ws, rs, hA, hB;
    if (!rstN) begin
      for (int i = 0; i < DEP; i++) mMem[i] = 8'hFF;
      for (int i = 0; i < 128; i++) mBuf[i] = 8'hFF;
      expOut = 8'h00; lastD = 8'h00; mst = 0; busyLeft = 0; ldT = 0; ldPage = 0;
      mId = 0; busyErase = 0; ldAny = 0; tog = 0; mWrQ = 0; mRdQ = 0;
    end else begin
      wa = !ceN && !weN;
      ra = !ceN && !oeN && weN;
      ws = wa && !mWrQ;
      rs = ra && !mRdQ;
      mWrQ = wa;
      mRdQ = ra;
      hA = (addr[14:0] == 15'h5555);
      hB = (addr[14:0] == 15'h2AAA);
      if (busyLeft > 0) begin
        if (rs) begin
          tog = !tog;
          expOut = {~lastD[7], tog, 6'b0};
        end
        busyLeft--;
        if (busyLeft == 0) begin
          if (busyErase) for (int i = 0; i < DEP; i++) mMem[i] = 8'hFF;
          else for (int i = 0; i < 128; i++) mMem[ldPage * 128 + i] = mBuf[i];
        end
      end else begin
        if (rs) begin
          if (mId) expOut = (addr == 16'h0000) ? 8'hBF : (addr == 16'h0001) ? 8'h5D : 8'h00;
          else expOut = mMem[addr % DEP];
        end
        case (mst)
          0: if (ws && hA && dataIn == 8'hAA) mst = 1;
          1: if (ws) mst = (hB && dataIn == 8'h55) ? 2 : 0;
          2: if (ws) begin
               mst = 0;
               if (hA) begin
                 if (dataIn == 8'hA0) begin
                   mst = 6; ldT = 0; ldAny = 0;
                   for (int i = 0; i < 128; i++) mBuf[i] = 8'hFF;
                 end
                 else if (dataIn == 8'h90) mId = 1;
                 else if (dataIn == 8'hF0) mId = 0;
                 else if (dataIn == 8'h80) mst = 3;
               end
             end
          3: if (ws) mst = (hA && dataIn == 8'hAA) ? 4 : 0;
          4: if (ws) mst = (hB && dataIn == 8'h55) ? 5 : 0;
          5: if (ws) begin
               mst = 0;
               if (hA && dataIn == 8'h10) begin
                 busyLeft = ER; busyErase = 1; lastD = 8'hFF; tog = 0;
               end
             end
          6: if (ws) begin
               mBuf[addr[6:0]] = dataIn;
               lastD = dataIn;
               if (!ldAny) ldPage = int'(addr[9:7]);
               ldAny = 1; ldT = 0;
             end else if (ldT == LT - 1) begin
               mst = 0;
               if (ldAny) begin busyLeft = WR; busyErase = 0; tog = 0; end
             end else ldT++;
          default: mst = 0;
        endcase
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      nChk++;
      if (dataOut !== expOut) begin
        nBad++;
        $display("FAIL %s model compare: dataOut=%h expected=%h at %0t", curReq, dataOut, expOut, $time);
      end
    end
  end

  task automatic wrHold(input logic [15:0] a, input logic [7:0] d, input int n);
    @(negedge clk);
    addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    repeat (n) @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wrHold(a, d, 1);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk);
    v = dataOut;
    oeN = 1'b1; ceN = 1'b1;
  endtask

  task automatic rdChk(input logic [15:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd(a, v);
    nChk++;
    if (v !== exp) begin
      nBad++;
      $display("FAIL %s read %h: actual=%h expected=%h", req, a, v, exp);
    end
  endtask

  task automatic unlockLoad(input logic [15:0] hi);
    wr(hi | 16'h5555, 8'hAA);
    wr(hi | 16'h2AAA, 8'h55);
    wr(hi | 16'h5555, 8'hA0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nBad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChk++;
    if (dataOut !== 8'h00) begin
      nBad++;
      $display("FAIL R2 reset value: actual=%h expected=00", dataOut);
    end
    rstN = 1'b1;

    curReq = "R1";
    rdChk(16'h0000, 8'hFF, "R1");
    rdChk(16'h03FF, 8'hFF, "R1");

    curReq = "R10";
    wr(16'h0010, 8'h12);
    idle(LT + 5);
    rdChk(16'h0010, 8'hFF, "R10");

    // R4: unlock with address bit 15 set, load four bytes in page 2
    curReq = "R4";
    unlockLoad(16'h8000);
    for (int i = 0; i < 4; i++) wr(16'h0100 + 16'(i), 8'h30 + 8'(i));
    idle(LT + 2);
    curReq = "R7";
    rdChk(16'h0000, 8'hC0, "R7");
    curReq = "R8";
    rdChk(16'h1234, 8'h80, "R8");
    rdChk(16'h0102, 8'hC0, "R8");
    curReq = "R9";
    for (int i = 0; i < 110; i++) rd(16'h0102, v);
    rdChk(16'h0102, 8'h32, "R9");
    rdChk(16'h0100, 8'h30, "R5");
    rdChk(16'h0110, 8'hFF, "R5");
    rdChk(16'h2102, 8'h32, "R1");

    // R5: rewrite page 2 with a later byte pointing at another page
    curReq = "R5";
    unlockLoad(16'h0000);
    wr(16'h0105, 8'h5A);
    wr(16'h0181, 8'hA5);
    idle(LT + 2);
    rdChk(16'h0105, 8'h40, "R7");
    idle(WR);
    rdChk(16'h0102, 8'hFF, "R5");
    rdChk(16'h0105, 8'h5A, "R5");
    rdChk(16'h0101, 8'hA5, "R5");
    rdChk(16'h0181, 8'hFF, "R5");

    // R10: writes inside a busy cycle
    curReq = "R10";
    unlockLoad(16'h0000);
    wr(16'h0300, 8'h01);
    idle(LT + 2);
    unlockLoad(16'h0000);
    wr(16'h0200, 8'h11);
    idle(WR + LT + 10);
    rdChk(16'h0200, 8'hFF, "R10");
    rdChk(16'h0300, 8'h01, "R10");

    // R6: unlock with no bytes loaded
    curReq = "R6";
    unlockLoad(16'h0000);
    idle(LT + 4);
    rdChk(16'h0105, 8'h5A, "R6");

    // R11: broken sequences
    curReq = "R11";
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
    wr(16'h1234, 8'hA0);
    wr(16'h0200, 8'h77);
    idle(LT + 4);
    rdChk(16'h0200, 8'hFF, "R11");
    wr(16'h5555, 8'hAA);
    wr(16'h2AAB, 8'h55);
    unlockLoad(16'h0000);
    wr(16'h0201, 8'h3C);
    idle(LT + WR + 4);
    rdChk(16'h0201, 8'h3C, "R11");

    // R3: a command write held low for several cycles counts once
    curReq = "R3";
    wrHold(16'h5555, 8'hAA, 4);
    wr(16'h2AAA, 8'h55);
    wr(16'h5555, 8'hA0);
    wrHold(16'h0300, 8'h66, 3);
    idle(LT + WR + 4);
    rdChk(16'h0300, 8'h66, "R3");

    // R12: identification mode
    curReq = "R12";
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
    wr(16'h5555, 8'h90);
    rdChk(16'h0000, 8'hBF, "R12");
    rdChk(16'h0001, 8'h5D, "R12");
    rdChk(16'h0005, 8'h00, "R12");
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
    wr(16'h5555, 8'hF0);
    rdChk(16'h0105, 8'h5A, "R12");

    // R13: chip erase
    curReq = "R13";
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
    wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
    wr(16'h5555, 8'h10);
    rdChk(16'h0105, 8'h40, "R13");
    rdChk(16'h0105, 8'h00, "R13");
    idle(ER + 4);
    rdChk(16'h0105, 8'hFF, "R13");
    rdChk(16'h0300, 8'hFF, "R13");

    idle(4);
    summary();
  end

endmodule